// File: doc/BRIEF.md
# Microcoded Serial Flash Sequencer

This block drives a serial flash over one, two or four data lines. Software does not choose from a fixed set of flash commands. It writes small programs into a 64-word instruction table. Each 32-bit word holds two 16-bit instructions, and a group of four words forms one of 16 sequence slots. Each instruction names one bus action, the number of lines that action uses, and an 8-bit argument. The bus actions are opcode byte, address, dummy clocks, data in and data out.

Software first writes a flash address. It then writes a trigger word that carries the slot number and a transfer length. The engine lowers chip select and works through the slot one instruction at a time. Outgoing data comes from a transmit FIFO and incoming bytes go to a receive FIFO. The engine raises chip select again at the end of the slot. It then posts a completion flag, and that flag can drive an interrupt. A key-then-command handshake protects the table against accidental writes.

The register port is word addressed. Offset 0 is trigger, 1 is flags, 2 is interrupt enable, 3 is address, 4 is key, 5 is lock control and 6 is status. Table words sit at offsets 64 to 127.

Top module: `sflash_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io_oe is 0 and irq is 0. The flags register reads 0. The status register (bit 0 busy, bit 1 table locked) reads 2.
- R2: At reset the table is locked, and table writes made while it is locked leave the stored word unchanged. It unlocks only when the value 0x5AF05AF0 is written to the key offset and the very next register write puts 2 into the lock offset. Key then 1 relocks it. A lock write that does not directly follow a correct key write has no effect.
- R3: The trigger word carries the slot number in bits [27:24] and the length in bits [15:0]. Slot n executes words 4n to 4n+3, and the lower 16 bits of each word run before the upper 16. Each instruction holds its argument in [7:0], its line code in [9:8] and its opcode in [15:10]. Line code 0 uses one line, 1 uses two lines and 2 uses four lines.
- R4: Opcode 1 sends its argument as one byte, most significant bit first. One line uses io[0], two lines use io[1:0] and four lines use io[3:0], with a matching io_oe mask. Output data changes only while sck is low.
- R5: Opcode 2 sends the lowest N bits of the address register, most significant first, where N is the argument (24 or 32).
- R6: Opcode 3 produces as many sck pulses as its argument, with io_oe at 0 throughout.
- R7: Opcode 7 receives as many bytes as its argument, most significant bit first. With one line it samples io_in[1], with two lines io_in[1:0] and with four lines io_in[3:0]. Sampling happens at the end of each sck high phase, and each byte is appended to the receive FIFO.
- R8: Opcode 8 sends the trigger length in bytes, popped in order from the transmit FIFO.
- R9: A slot ends at opcode 0, at any opcode not listed in R4 to R8, or after its eighth instruction. cs_n stays low for the whole slot and is 1 once the slot ends.
- R10: Flags bit 0 is set at the end of every slot and is cleared by writing 1 to it. irq is high when that bit and interrupt-enable bit 0 are both set.
- R11: A trigger written while the engine is busy is dropped and sets flags bit 1, which is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Serial data in |

## Verification
A bench-side flash model records the lines at every rising sck. It also drives a different nibble on each pulse, so a wrong bit order or a wrong sampling lane gives different bytes. Several programs are run against it: a single-line opcode with a 24-bit address, dummy clocks and a quad read; a dual-line opcode with a 32-bit quad address and a quad write; a single-line read; an eight-instruction slot with no stop; and a slot cut short by an undefined opcode. These runs separate lane mapping, field order, slot addressing and the end conditions. The lock handshake is tested with a correct key, a wrong key, an interrupted key and a missing key. A trigger issued during a long slot shows that the dropped request neither extends the slot nor starts a second one.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [5:0] {
    OP_STOP  = 6'd0,
    OP_CMD   = 6'd1,
    OP_ADDR  = 6'd2,
    OP_DUMMY = 6'd3,
    OP_READ  = 6'd7,
    OP_WRITE = 6'd8
  } sfs_op_e;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] lanes;
    logic [7:0] arg;
  } sfs_instr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_NEXT,
    ST_FINISH
  } sfs_state_e;

  localparam logic [31:0] SFS_KEY = 32'h5AF0_5AF0;
  localparam logic [31:0] LOCK_CMD_LOCK   = 32'd1;
  localparam logic [31:0] LOCK_CMD_UNLOCK = 32'd2;

  localparam int REG_TRIG   = 0;
  localparam int REG_FLAGS  = 1;
  localparam int REG_IEN    = 2;
  localparam int REG_ADDR   = 3;
  localparam int REG_KEY    = 4;
  localparam int REG_LOCK   = 5;
  localparam int REG_STATUS = 6;

  // log2 of the number of active lines for a line code
  function automatic logic [1:0] lane_log2(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // shifter steps needed to move one byte
  function automatic logic [7:0] steps_per_byte(input logic [1:0] lg);
    return 8'd8 >> lg;
  endfunction

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         valid,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [AW:0]   cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign valid   = (cnt_q != '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = wp_q + 1'b1;
    if (do_pop)  rp_n = rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

endmodule

// File: rtl/sfs_table.sv
module sfs_table #(
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr_eng,
  output logic [31:0]   rdata_eng,
  input  logic [AW-1:0] raddr_reg,
  output logic [31:0]   rdata_reg
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_eng = mem[raddr_eng];
  assign rdata_reg = mem[raddr_reg];

endmodule

// File: rtl/sfs_regs.sv
module sfs_regs
  import sfs_pkg::*;
#(
  parameter int SEQ_W  = 4,
  parameter int LEN_W  = 16,
  parameter int TBL_AW = 6,
  localparam int RA_W  = TBL_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_idx,
  input  logic [31:0]       tbl_rdata,
  output logic              trig,
  output logic [SEQ_W-1:0]  trig_seq,
  output logic [LEN_W-1:0]  trig_len,
  output logic [31:0]       flash_addr,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              ie_en,
  output logic              flag_done,
  output logic              flag_err,
  output logic              irq
);

  logic locked_q, locked_n;
  logic key_ok_q, key_ok_n;
  logic ie_q, ie_n;
  logic done_q, done_n;
  logic err_q, err_n;
  logic [31:0] addr_q, addr_n;
  logic sel_tbl;
  logic wr_trig, wr_flags, wr_ien, wr_addr, wr_key, wr_lock;

  assign sel_tbl  = reg_addr[RA_W-1];
  assign tbl_idx  = reg_addr[TBL_AW-1:0];
  assign wr_trig  = reg_we && !sel_tbl && (reg_addr == RA_W'(REG_TRIG));
  assign wr_flags = reg_we && !sel_tbl && (reg_addr == RA_W'(REG_FLAGS));
  assign wr_ien   = reg_we && !sel_tbl && (reg_addr == RA_W'(REG_IEN));
  assign wr_addr  = reg_we && !sel_tbl && (reg_addr == RA_W'(REG_ADDR));
  assign wr_key   = reg_we && !sel_tbl && (reg_addr == RA_W'(REG_KEY));
  assign wr_lock  = reg_we && !sel_tbl && (reg_addr == RA_W'(REG_LOCK));

  assign tbl_we   = reg_we && sel_tbl && !locked_q;
  assign trig     = wr_trig;
  assign trig_seq = reg_wdata[24 +: SEQ_W];
  assign trig_len = reg_wdata[LEN_W-1:0];

  assign flash_addr = addr_q;
  assign ie_en      = ie_q;
  assign flag_done  = done_q;
  assign flag_err   = err_q;
  assign irq        = done_q && ie_q;

  always_comb begin
    locked_n = locked_q;
    key_ok_n = key_ok_q;
    ie_n     = ie_q;
    addr_n   = addr_q;
    // every register write consumes a pending key
    if (reg_we) key_ok_n = 1'b0;
    if (wr_key) key_ok_n = (reg_wdata == SFS_KEY);
    if (wr_lock && key_ok_q) begin
      if (reg_wdata == LOCK_CMD_UNLOCK)    locked_n = 1'b0;
      else if (reg_wdata == LOCK_CMD_LOCK) locked_n = 1'b1;
    end
    if (wr_ien)  ie_n   = reg_wdata[0];
    if (wr_addr) addr_n = reg_wdata;
    done_n = (done_q && !(wr_flags && reg_wdata[0])) || eng_done;
    err_n  = (err_q && !(wr_flags && reg_wdata[1])) || (wr_trig && eng_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      key_ok_q <= 1'b0;
      ie_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
    end else begin
      locked_q <= locked_n;
      key_ok_q <= key_ok_n;
      ie_q     <= ie_n;
      done_q   <= done_n;
      err_q    <= err_n;
      addr_q   <= addr_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_tbl) reg_rdata = tbl_rdata;
    else begin
      case (reg_addr)
        RA_W'(REG_FLAGS):  reg_rdata = {30'd0, err_q, done_q};
        RA_W'(REG_IEN):    reg_rdata = {31'd0, ie_q};
        RA_W'(REG_ADDR):   reg_rdata = addr_q;
        RA_W'(REG_STATUS): reg_rdata = {30'd0, locked_q, eng_busy};
        default:           reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sfs_engine.sv
module sfs_engine
  import sfs_pkg::*;
#(
  parameter int INSTR_PER_SEQ = 8,
  parameter int SEQ_W         = 4,
  parameter int LEN_W         = 16,
  localparam int PTR_W        = $clog2(INSTR_PER_SEQ),
  localparam int TA_W         = SEQ_W + PTR_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEQ_W-1:0] seq_id,
  input  logic [LEN_W-1:0] len,
  input  logic [31:0]      addr,
  output logic [TA_W-1:0]  tbl_raddr,
  input  logic [31:0]      tbl_rdata,
  input  logic [7:0]       tx_byte,
  input  logic             tx_valid,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             done,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);

  sfs_state_e       state_q, state_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [SEQ_W-1:0] seq_q, seq_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [31:0]      addr_q, addr_n;
  logic [5:0]       op_q, op_n;
  logic [1:0]       lg_q, lg_n;
  logic [31:0]      sh_q, sh_n;
  logic [7:0]       units_q, units_n;
  logic [LEN_W-1:0] bytes_q, bytes_n;
  logic             phase_q, phase_n;
  logic [7:0]       rxs_q, rxs_n;

  sfs_instr_t ins;
  logic [1:0] lg_ins;
  logic [5:0] abits;
  logic [7:0] rx_cat;
  logic       drive, is_data;
  logic [7:0] tx_next;

  assign tbl_raddr = {seq_q, ptr_q[PTR_W-1:1]};
  assign ins       = ptr_q[0] ? tbl_rdata[31:16] : tbl_rdata[15:0];
  assign lg_ins    = lane_log2(ins.lanes);
  assign abits     = (ins.arg > 8'd32) ? 6'd32 : ins.arg[5:0];
  assign tx_next   = tx_valid ? tx_byte : 8'h00;
  assign is_data   = (op_q == OP_READ) || (op_q == OP_WRITE);

  always_comb begin
    case (lg_q)
      2'd0:    rx_cat = {rxs_q[6:0], io_in[1]};
      2'd1:    rx_cat = {rxs_q[5:0], io_in[1:0]};
      default: rx_cat = {rxs_q[3:0], io_in[3:0]};
    endcase
  end
  assign rx_byte = rx_cat;

  // pin drivers
  assign drive = (state_q == ST_SHIFT) &&
                 ((op_q == OP_CMD) || (op_q == OP_ADDR) || (op_q == OP_WRITE));
  always_comb begin
    io_out = 4'h0;
    io_oe  = 4'h0;
    if (drive) begin
      case (lg_q)
        2'd0:    begin io_out = {3'b0, sh_q[31]};    io_oe = 4'b0001; end
        2'd1:    begin io_out = {2'b0, sh_q[31:30]}; io_oe = 4'b0011; end
        default: begin io_out = sh_q[31:28];         io_oe = 4'b1111; end
      endcase
    end
  end

  assign sck  = (state_q == ST_SHIFT) && phase_q;
  assign cs_n = !((state_q == ST_FETCH) || (state_q == ST_SHIFT) || (state_q == ST_NEXT));
  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    seq_n   = seq_q;
    len_n   = len_q;
    addr_n  = addr_q;
    op_n    = op_q;
    lg_n    = lg_q;
    sh_n    = sh_q;
    units_n = units_q;
    bytes_n = bytes_q;
    phase_n = phase_q;
    rxs_n   = rxs_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          seq_n   = seq_id;
          len_n   = len;
          addr_n  = addr;
          ptr_n   = '0;
          state_n = ST_FETCH;
        end
      end
      ST_FETCH: begin
        op_n    = ins.op;
        lg_n    = lg_ins;
        phase_n = 1'b0;
        rxs_n   = '0;
        units_n = steps_per_byte(lg_ins);
        case (ins.op)
          OP_CMD: begin
            sh_n    = {ins.arg, 24'h0};
            state_n = ST_SHIFT;
          end
          OP_ADDR: begin
            sh_n    = addr_q << (6'd32 - abits);
            units_n = {2'b0, abits >> lg_ins};
            state_n = (abits == '0) ? ST_NEXT : ST_SHIFT;
          end
          OP_DUMMY: begin
            sh_n    = '0;
            units_n = ins.arg;
            state_n = (ins.arg == '0) ? ST_NEXT : ST_SHIFT;
          end
          OP_READ: begin
            bytes_n = LEN_W'(ins.arg);
            state_n = (ins.arg == '0) ? ST_NEXT : ST_SHIFT;
          end
          OP_WRITE: begin
            bytes_n = len_q;
            sh_n    = {tx_next, 24'h0};
            tx_pop  = tx_valid && (len_q != '0);
            state_n = (len_q == '0) ? ST_NEXT : ST_SHIFT;
          end
          default: state_n = ST_FINISH;
        endcase
      end
      ST_SHIFT: begin
        if (!phase_q) begin
          phase_n = 1'b1;
        end else begin
          phase_n = 1'b0;
          sh_n    = sh_q << (6'd1 << lg_q);
          rxs_n   = rx_cat;
          units_n = units_q - 1'b1;
          if (units_q == 8'd1) begin
            rx_push = (op_q == OP_READ);
            if (is_data && (bytes_q > LEN_W'(1))) begin
              bytes_n = bytes_q - 1'b1;
              units_n = steps_per_byte(lg_q);
              if (op_q == OP_WRITE) begin
                sh_n   = {tx_next, 24'h0};
                tx_pop = tx_valid;
              end
            end else begin
              state_n = ST_NEXT;
            end
          end
        end
      end
      ST_NEXT: begin
        if (ptr_q == PTR_W'(INSTR_PER_SEQ - 1)) state_n = ST_FINISH;
        else begin
          ptr_n   = ptr_q + 1'b1;
          state_n = ST_FETCH;
        end
      end
      ST_FINISH: begin
        done    = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      seq_q   <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      op_q    <= '0;
      lg_q    <= '0;
      sh_q    <= '0;
      units_q <= '0;
      bytes_q <= '0;
      phase_q <= 1'b0;
      rxs_q   <= '0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      seq_q   <= seq_n;
      len_q   <= len_n;
      addr_q  <= addr_n;
      op_q    <= op_n;
      lg_q    <= lg_n;
      sh_q    <= sh_n;
      units_q <= units_n;
      bytes_q <= bytes_n;
      phase_q <= phase_n;
      rxs_q   <= rxs_n;
    end
  end

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int TBL_WORDS     = 64,
  parameter int INSTR_PER_SEQ = 8,
  parameter int FIFO_DEPTH    = 16,
  parameter int LEN_W         = 16,
  localparam int TBL_AW       = $clog2(TBL_WORDS),
  localparam int SEQ_W        = $clog2(TBL_WORDS / (INSTR_PER_SEQ / 2)),
  localparam int RA_W         = TBL_AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            tx_push,
  input  logic [7:0]      tx_data,
  output logic            tx_full,
  input  logic            rx_pop,
  output logic [7:0]      rx_data,
  output logic            rx_valid,
  output logic            irq,
  output logic            sck,
  output logic            cs_n,
  output logic [3:0]      io_out,
  output logic [3:0]      io_oe,
  input  logic [3:0]      io_in
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              tbl_we;
  logic [TBL_AW-1:0] tbl_idx, tbl_raddr;
  logic [31:0]       tbl_rdata_eng, tbl_rdata_reg;
  logic              trig;
  logic [SEQ_W-1:0]  trig_seq;
  logic [LEN_W-1:0]  trig_len;
  logic [31:0]       flash_addr;
  logic              eng_busy, eng_done;
  logic              ie_en, flag_done, flag_err;
  logic [7:0]        tx_byte, rx_byte;
  logic              tx_valid, tx_pop, rx_push, rx_full;

  sfs_regs #(.SEQ_W(SEQ_W), .LEN_W(LEN_W), .TBL_AW(TBL_AW)) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_rdata(tbl_rdata_reg),
    .trig(trig), .trig_seq(trig_seq), .trig_len(trig_len), .flash_addr(flash_addr),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .ie_en(ie_en), .flag_done(flag_done), .flag_err(flag_err), .irq(irq)
  );

  sfs_table #(.WORDS(TBL_WORDS)) table_i (
    .clk(clk), .we(tbl_we), .waddr(tbl_idx), .wdata(reg_wdata),
    .raddr_eng(tbl_raddr), .rdata_eng(tbl_rdata_eng),
    .raddr_reg(tbl_idx), .rdata_reg(tbl_rdata_reg)
  );

  sfs_engine #(.INSTR_PER_SEQ(INSTR_PER_SEQ), .SEQ_W(SEQ_W), .LEN_W(LEN_W)) engine_i (
    .clk(clk), .rst_n(rst_sync_n),
    .start(trig), .seq_id(trig_seq), .len(trig_len), .addr(flash_addr),
    .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata_eng),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte),
    .busy(eng_busy), .done(eng_done),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  sfs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push(tx_push), .wdata(tx_data), .pop(tx_pop),
    .rdata(tx_byte), .valid(tx_valid), .full(tx_full)
  );

  sfs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
    .rdata(rx_data), .valid(rx_valid), .full(rx_full)
  );

endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk #(
  parameter int RA_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sck,
  input logic            cs_n,
  input logic [3:0]      io_out,
  input logic [3:0]      io_oe,
  input logic            irq,
  input logic            busy,
  input logic            done,
  input logic            ie_en,
  input logic            flag_done,
  input logic            flag_err,
  input logic            reg_we,
  input logic [RA_W-1:0] reg_addr,
  input logic            rx_push
);

  // R9
  cs_idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R4
  oe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'h0) |-> !cs_n);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> ($stable(io_out) && $stable(io_oe)));

  // R7
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !cs_n);

  // R10
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_done);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ie_en) |=> irq);

  // R11
  busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == RA_W'(0)) && busy) |=> (flag_err && busy));

endmodule

bind sflash_seq sflash_seq_chk #(.RA_W(RA_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .sck(sck), .cs_n(cs_n),
  .io_out(io_out), .io_oe(io_oe), .irq(irq),
  .busy(eng_busy), .done(eng_done), .ie_en(ie_en),
  .flag_done(flag_done), .flag_err(flag_err),
  .reg_we(reg_we), .reg_addr(reg_addr), .rx_push(rx_push)
);

// File: tb/sflash_seq_tb.sv
module sflash_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h5AF0_5AF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_push = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_full;
  logic        rx_pop = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        irq, sck, cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  int nchk = 0;
  int nerr = 0;
  int ncap = 0;
  logic [3:0] cap_out [512];
  logic [3:0] cap_oe  [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
    .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_valid(rx_valid), .irq(irq), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [3:0] pat(int i);
    return 4'((i * 7 + 3) & 15);
  endfunction

  // flash model: record lines and present the nibble for this pulse
  always @(posedge sck) begin
    if (ncap < 512) begin
      cap_out[ncap] = io_out;
      cap_oe[ncap]  = io_oe;
    end
    io_in = pat(ncap);
    ncap  = ncap + 1;
  end

  function automatic logic [15:0] ins(int op, int ln, int arg);
    return {op[5:0], ln[1:0], arg[7:0]};
  endfunction

  function automatic logic [31:0] gather(int start, int n, int lg);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++)
      v = (v << (1 << lg)) | 32'(cap_out[start+i] & 4'((1 << (1 << lg)) - 1));
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load_slot(int slot, logic [15:0] i0, i1, i2, i3, i4, i5, i6, i7);
    wr(7'(64 + slot*4 + 0), {i1, i0});
    wr(7'(64 + slot*4 + 1), {i3, i2});
    wr(7'(64 + slot*4 + 2), {i5, i4});
    wr(7'(64 + slot*4 + 3), {i7, i6});
  endtask

  task automatic run(int slot, int len);
    logic [31:0] d;
    ncap = 0;
    wr(7'd0, (32'(slot) << 24) | 32'(len));
    for (int i = 0; i < 5000; i++) begin
      rd(7'd1, d);
      if (d[0]) break;
    end
  endtask

  task automatic pop_byte(output logic [7:0] b);
    @(negedge clk);
    b = rx_data;
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 cs_n", 32'(cs_n), 1);
    chk("R1 sck", 32'(sck), 0);
    chk("R1 io_oe", 32'(io_oe), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(7'd1, d); chk("R1 flags", d, 0);
    rd(7'd6, d); chk("R1 status", d, 2);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr(7'd5, 2);
    rd(7'd6, d); chk("R2 lock without key", d, 2);
    wr(7'd4, 32'h1234_5678); wr(7'd5, 2);
    rd(7'd6, d); chk("R2 wrong key", d, 2);
    wr(7'd4, KEY); wr(7'd5, 2);
    rd(7'd6, d); chk("R2 unlock", d, 0);
    wr(7'd64, 32'h1111_1111);
    rd(7'd64, d); chk("R2 write while open", d, 32'h1111_1111);
    wr(7'd4, KEY); wr(7'd5, 1);
    rd(7'd6, d); chk("R2 relock", d, 2);
    wr(7'd64, 32'h2222_2222);
    rd(7'd64, d); chk("R2 write while locked", d, 32'h1111_1111);
    wr(7'd4, KEY); wr(7'd3, 0); wr(7'd5, 2);
    rd(7'd6, d); chk("R2 interrupted key", d, 2);
    wr(7'd4, KEY); wr(7'd5, 2);
    rd(7'd6, d); chk("R2 unlock again", d, 0);
  endtask

  task automatic t_quad_read;
    logic [31:0] d;
    logic [7:0] b;
    int oe_bad = 0;
    load_slot(3, ins(1,0,8'h6B), ins(2,0,8'h18), ins(3,0,8), ins(7,2,2),
              ins(0,0,0), 0, 0, 0);
    wr(7'd3, 32'hAB12_3456);
    run(3, 0);
    chk("R9 cs released", 32'(cs_n), 1);
    chk("R3 pulse count", 32'(ncap), 44);
    chk("R4 single cmd", gather(0, 8, 0), 32'h6B);
    chk("R4 single oe", 32'(cap_oe[0]), 1);
    chk("R5 24-bit addr", gather(8, 24, 0), 32'h12_3456);
    for (int i = 32; i < 40; i++) if (cap_oe[i] != 4'h0) oe_bad++;
    chk("R6 dummy oe low", 32'(oe_bad), 0);
    pop_byte(b); chk("R7 quad byte0", 32'(b), 32'({pat(40), pat(41)}));
    pop_byte(b); chk("R7 quad byte1", 32'(b), 32'({pat(42), pat(43)}));
    chk("R7 rx empty", 32'(rx_valid), 0);
    rd(7'd1, d); chk("R10 done flag", d, 1);
    chk("R10 irq off when disabled", 32'(irq), 0);
    wr(7'd1, 1);
    rd(7'd1, d); chk("R10 done cleared", d, 0);
  endtask

  task automatic t_quad_write;
    logic [31:0] d;
    load_slot(5, ins(1,1,8'h38), ins(2,2,8'h20), ins(8,2,0), ins(0,0,0),
              0, 0, 0, 0);
    wr(7'd3, 32'h89AB_CDEF);
    @(negedge clk); tx_push = 1'b1; tx_data = 8'hA5;
    @(negedge clk); tx_data = 8'h3C;
    @(negedge clk); tx_data = 8'hF0;
    @(negedge clk); tx_push = 1'b0;
    run(5, 3);
    chk("R8 pulse count", 32'(ncap), 18);
    chk("R4 dual cmd", gather(0, 4, 1), 32'h38);
    chk("R4 dual oe", 32'(cap_oe[0]), 32'h3);
    chk("R5 32-bit quad addr", gather(4, 8, 2), 32'h89AB_CDEF);
    chk("R8 write bytes", gather(12, 6, 2), 32'hA5_3CF0);
    chk("R8 quad oe", 32'(cap_oe[12]), 32'hF);
    wr(7'd1, 1);
  endtask

  task automatic t_single_read;
    logic [7:0] b, e;
    load_slot(2, ins(1,0,8'h05), ins(7,0,1), 0, 0, 0, 0, 0, 0);
    run(2, 0);
    e = '0;
    for (int i = 8; i < 16; i++) e = {e[6:0], pat(i)[1]};
    pop_byte(b);
    chk("R7 single-line byte", 32'(b), 32'(e));
    chk("R3 slot 2 pulses", 32'(ncap), 16);
    wr(7'd1, 1);
  endtask

  task automatic t_end_rules;
    load_slot(15, ins(1,0,8'h10), ins(1,0,8'h11), ins(1,0,8'h12), ins(1,0,8'h13),
              ins(1,0,8'h14), ins(1,0,8'h15), ins(1,0,8'h16), ins(1,0,8'h17));
    run(15, 0);
    chk("R9 eight instructions", 32'(ncap), 64);
    for (int k = 0; k < 8; k += 7)
      chk("R3 lower half first order", gather(8*k, 8, 0), 32'(8'h10 + k));
    wr(7'd1, 1);
    load_slot(7, ins(1,0,8'h9F), ins(5,0,0), ins(1,0,8'h01), 0, 0, 0, 0, 0);
    run(7, 0);
    chk("R9 undefined opcode stops", 32'(ncap), 8);
    chk("R9 cs high after", 32'(cs_n), 1);
    wr(7'd1, 1);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(7'd2, 1);
    run(2, 0);
    @(negedge clk);
    chk("R10 irq raised", 32'(irq), 1);
    wr(7'd1, 1);
    chk("R10 irq cleared", 32'(irq), 0);
    rd(7'd1, d); chk("R10 flags after clear", d, 0);
    wr(7'd2, 0);
    while (rx_valid) pop_byte(tx_data);
    tx_data = '0;
  endtask

  task automatic t_busy_trigger;
    logic [31:0] d;
    ncap = 0;
    wr(7'd0, 32'h0F00_0000);
    wr(7'd0, 32'h0300_0000);
    for (int i = 0; i < 5000; i++) begin
      rd(7'd1, d);
      if (d[0]) break;
    end
    repeat (200) @(negedge clk);
    chk("R11 error flag", d & 32'h2, 2);
    chk("R11 dropped trigger", 32'(ncap), 64);
    rd(7'd6, d); chk("R11 idle after", d & 32'h1, 0);
    wr(7'd1, 3);
    rd(7'd1, d); chk("R11 flags cleared", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lock();
    t_quad_read();
    t_quad_write();
    t_single_read();
    t_end_rules();
    t_irq();
    t_busy_trigger();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule